// File: doc/BRIEF.md
# Attribute Memory Address Decoder

This block sits between a simplified 16-bit host bus and the two stores that back a card's attribute memory window: a small internal card-information RAM (512 bytes of window, 256 byte entries) and an external parallel nonvolatile memory. For every host access it decides which store answers. The decision uses the byte address and whether a serial configuration memory was detected at start-up. The internal RAM is filled only by a separate loader block. The host can read it but cannot write it.

For an external access the block asserts an active-low chip select (and an active-low write enable on writes) and registers the address for the external device. It also withdraws its own drive of the shared data bus. For an internal read it looks up the RAM entry at half the byte address and drives the byte on the low lane. The high lane is always zero, and odd byte addresses read as zero, so that 8-bit hosts see the attribute space as even bytes only.

All results appear one clock edge after the cycle in which the access request is sampled.

Top module: `attr_mem_decoder`

## Requirements
- R1: The internal RAM index output `cis_idx` equals the host byte address shifted right by one (address bits [8:1]). It follows the address combinationally, in the same cycle.
- R2: When `serial_ok`=1 and the address is below 0x200, a read is internal. One edge later `ext_cs_n`=1, `ext_we_n`=1 and `rd_oe`=1, and the low byte of `rd_data` holds the RAM byte.
- R3: When `serial_ok`=0, every access, including addresses 0x000–0x1FF, is external. One edge later `ext_cs_n`=0.
- R4: An access at an address of 0x200 or above is external whatever `serial_ok` is. One edge later `ext_cs_n`=0 and `ext_addr` holds the access address.
- R5: In the cycle where `ext_cs_n`=0, `rd_oe`=0 and `rd_data`=0.
- R6: `ext_we_n` goes low only for an external access with `host_wr`=1, and always together with `ext_cs_n`=0. An external read leaves `ext_we_n`=1.
- R7: `rd_data[15:8]` is always zero.
- R8: An internal byte read (`host_word`=0) at an odd address (bit 0 = 1) returns `rd_data`=0x0000 with `rd_oe`=1.
- R9: An internal word read (`host_word`=1) ignores address bit 0 and returns the even RAM byte on `rd_data[7:0]`.
- R10: A host write to the internal region is ignored. It leaves both strobes high and `rd_oe`=0, and a later read of that address returns the unchanged RAM byte.
- R11: After reset, and one edge after any cycle with `host_req`=0, `ext_cs_n`=1, `ext_we_n`=1, `rd_oe`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_ok | input | 1 | Serial configuration memory was detected |
| host_req | input | 1 | Access request, sampled each edge |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_word | input | 1 | 1 = word access, 0 = byte access |
| host_addr | input | 15 | Attribute byte address |
| cis_idx | output | 8 | Index into the internal card-information RAM |
| cis_byte | input | 8 | Byte read from the internal RAM at `cis_idx` |
| ext_cs_n | output | 1 | External memory select, active low |
| ext_we_n | output | 1 | External memory write enable, active low |
| ext_addr | output | 15 | Registered address for the external memory |
| rd_data | output | 16 | Read data toward the host |
| rd_oe | output | 1 | Block drives the data bus when 1 |

## Verification
Only `cis_idx` is combinational. The bench checks it one time unit after it drives the address at a falling edge. Every other result (strobes, `ext_addr`, `rd_data`, `rd_oe`) passes through exactly one register. Each scenario task therefore drives its request at a falling edge, waits for the next falling edge (one rising edge later), and samples the outputs there before it withdraws the request. A second falling edge with `host_req`=0 then confirms that the outputs return to idle.

// File: rtl/attr_pkg.sv
package attr_pkg;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_INT  = 2'd1,
    DST_EXT  = 2'd2
  } attr_dst_e;

  // Destination of one access: the internal region is used only with a serial memory present.
  function automatic attr_dst_e f_pick_dst(input logic req, input logic serial,
                                           input logic below_cis);
    if (!req)                    return DST_NONE;
    else if (serial && below_cis) return DST_INT;
    else                         return DST_EXT;
  endfunction

  // Low-lane byte: odd byte accesses read as zero, word accesses take the even byte.
  function automatic logic [7:0] f_low_lane(input logic word, input logic a0,
                                            input logic [7:0] ram_byte);
    if (!word && a0) return 8'h00;
    else             return ram_byte;
  endfunction

endpackage

// File: rtl/attr_route.sv
module attr_route
  import attr_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int CIS_BYTES = 512,
  parameter int IDX_W     = 8
) (
  input  logic              req,
  input  logic              serial,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output attr_dst_e         dst
);
  localparam logic [ADDR_W-1:0] CIS_LIMIT = ADDR_W'(CIS_BYTES);

  logic below_cis;

  assign below_cis = (addr < CIS_LIMIT);
  assign idx       = addr[IDX_W:1];
  assign dst       = f_pick_dst(req, serial, below_cis);

  always_comb begin
    if (dst == DST_INT)
      assert (below_cis && serial) else $error("AST_INT_NEEDS_SERIAL"); // R2
  end
endmodule

// File: rtl/attr_strobe.sv
module attr_strobe
  import attr_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  attr_dst_e         dst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              cs_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] xaddr
);
  logic ev_ext_acc;
  logic ev_ext_wr;

  assign ev_ext_acc = (dst == DST_EXT);
  assign ev_ext_wr  = ev_ext_acc && wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n  <= 1'b1;
      we_n  <= 1'b1;
      xaddr <= '0;
    end else begin
      cs_n <= !ev_ext_acc;
      we_n <= !ev_ext_wr;
      if (ev_ext_acc) xaddr <= addr;
    end
  end

  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cs_n); // R6
  AST_EXT_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_ext_acc) |-> (xaddr == $past(addr))); // R4
endmodule

// File: rtl/attr_rdata.sv
module attr_rdata
  import attr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  attr_dst_e         dst,
  input  logic              wr,
  input  logic              word,
  input  logic              a0,
  input  logic [7:0]        ram_byte,
  output logic [DATA_W-1:0] rdata,
  output logic              oe
);
  localparam int HI_W = DATA_W - 8;

  logic ev_int_rd;
  logic ev_int_wr_drop;
  logic [7:0] lane_lo;

  assign ev_int_rd      = (dst == DST_INT) && !wr;
  assign ev_int_wr_drop = (dst == DST_INT) && wr;
  assign lane_lo        = f_low_lane(word, a0, ram_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      oe    <= 1'b0;
    end else begin
      oe    <= ev_int_rd;
      rdata <= ev_int_rd ? {{HI_W{1'b0}}, lane_lo} : '0;
    end
  end

  AST_HI_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:8] == '0); // R7
  AST_DROP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_int_wr_drop) |-> !oe); // R10
  AST_ODD_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_int_rd && !word && a0) |-> (oe && rdata == '0)); // R8
endmodule

// File: rtl/attr_mem_decoder.sv
module attr_mem_decoder
  import attr_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 16,
  parameter int CIS_BYTES = 512,
  localparam int IDX_W    = $clog2(CIS_BYTES / 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serial_ok,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic              host_word,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [IDX_W-1:0]  cis_idx,
  input  logic [7:0]        cis_byte,
  output logic              ext_cs_n,
  output logic              ext_we_n,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);
  attr_dst_e dst;
  logic      ev_idle;

  assign ev_idle = !host_req;

  attr_route #(.ADDR_W(ADDR_W), .CIS_BYTES(CIS_BYTES), .IDX_W(IDX_W)) u_route (
    .req    (host_req),
    .serial (serial_ok),
    .addr   (host_addr),
    .idx    (cis_idx),
    .dst    (dst)
  );

  attr_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk   (clk),
    .rst_n (rst_n),
    .dst   (dst),
    .wr    (host_wr),
    .addr  (host_addr),
    .cs_n  (ext_cs_n),
    .we_n  (ext_we_n),
    .xaddr (ext_addr)
  );

  attr_rdata #(.DATA_W(DATA_W)) u_rdata (
    .clk      (clk),
    .rst_n    (rst_n),
    .dst      (dst),
    .wr       (host_wr),
    .word     (host_word),
    .a0       (host_addr[0]),
    .ram_byte (cis_byte),
    .rdata    (rd_data),
    .oe       (rd_oe)
  );

  AST_EXT_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_cs_n |-> (!rd_oe && rd_data == '0)); // R5
  AST_NO_SERIAL_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_req && !serial_ok) |-> !ext_cs_n); // R3
  AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_req && serial_ok && host_addr < ADDR_W'(CIS_BYTES)) |-> (ext_cs_n && ext_we_n)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_idle) |-> (ext_cs_n && ext_we_n && !rd_oe)); // R11
endmodule

// File: tb/sim_attr_mem_decoder.sv
module sim_attr_mem_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        serial_ok = 1'b1;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_word = 1'b0;
  logic [14:0] host_addr = '0;
  logic [7:0]  cis_idx;
  logic [7:0]  cis_byte;
  logic        ext_cs_n, ext_we_n, rd_oe;
  logic [14:0] ext_addr;
  logic [15:0] rd_data;

  int n_run = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] ram_val(input logic [7:0] i);
    return 8'((i * 7) + 8'h3C);
  endfunction

  always_comb cis_byte = ram_val(cis_idx);

  attr_mem_decoder u0 (
    .clk(clk), .rst_n(rst_n), .serial_ok(serial_ok), .host_req(host_req),
    .host_wr(host_wr), .host_word(host_word), .host_addr(host_addr),
    .cis_idx(cis_idx), .cis_byte(cis_byte), .ext_cs_n(ext_cs_n),
    .ext_we_n(ext_we_n), .ext_addr(ext_addr), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic cs, input logic we,
                           input logic oe, input logic [15:0] d);
    chk({req, " cs_n"}, 32'(ext_cs_n), 32'(cs));
    chk({req, " we_n"}, 32'(ext_we_n), 32'(we));
    chk({req, " oe"},   32'(rd_oe),    32'(oe));
    chk({req, " data"}, 32'(rd_data),  32'(d));
  endtask

  // Drive at a falling edge; outputs are due one rising edge later.
  task automatic access(input logic ser, input logic wr, input logic word,
                        input logic [14:0] a);
    @(negedge clk);
    serial_ok = ser; host_req = 1'b1; host_wr = wr; host_word = word; host_addr = a;
    #1;
    chk("R1 idx", 32'(cis_idx), 32'(a[8:1]));
    @(negedge clk);
  endtask

  task automatic release_bus;
    host_req = 1'b0; host_wr = 1'b0;
  endtask

  task automatic t_reset;
    check_out("R11 reset", 1'b1, 1'b1, 1'b0, 16'h0);
  endtask

  task automatic t_int_reads;
    access(1'b1, 1'b0, 1'b0, 15'h0010);
    check_out("R2 int rd", 1'b1, 1'b1, 1'b1, {8'h00, ram_val(8'h08)});
    release_bus();
    access(1'b1, 1'b0, 1'b0, 15'h01FE);
    check_out("R2 R7 top entry", 1'b1, 1'b1, 1'b1, {8'h00, ram_val(8'hFF)});
    release_bus();
    access(1'b1, 1'b0, 1'b0, 15'h0020);
    check_out("R2 even byte", 1'b1, 1'b1, 1'b1, {8'h00, ram_val(8'h10)});
    release_bus();
  endtask

  task automatic t_lanes;
    access(1'b1, 1'b0, 1'b0, 15'h0011);
    check_out("R8 odd byte", 1'b1, 1'b1, 1'b1, 16'h0000);
    release_bus();
    access(1'b1, 1'b0, 1'b1, 15'h0011);
    check_out("R9 word", 1'b1, 1'b1, 1'b1, {8'h00, ram_val(8'h08)});
    release_bus();
  endtask

  task automatic t_external;
    access(1'b1, 1'b0, 1'b0, 15'h0200);
    check_out("R4 R5 R6 ext rd", 1'b0, 1'b1, 1'b0, 16'h0);
    chk("R4 ext_addr", 32'(ext_addr), 32'h0200);
    release_bus();
    access(1'b1, 1'b1, 1'b1, 15'h7FFE);
    check_out("R6 ext wr", 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R4 ext_addr top", 32'(ext_addr), 32'h7FFE);
    release_bus();
  endtask

  task automatic t_no_serial;
    access(1'b0, 1'b0, 1'b0, 15'h0010);
    check_out("R3 low rd", 1'b0, 1'b1, 1'b0, 16'h0);
    chk("R3 ext_addr", 32'(ext_addr), 32'h0010);
    release_bus();
    access(1'b0, 1'b1, 1'b0, 15'h0000);
    check_out("R3 R6 low wr", 1'b0, 1'b0, 1'b0, 16'h0);
    release_bus();
  endtask

  task automatic t_int_write;
    access(1'b1, 1'b1, 1'b1, 15'h0010);
    check_out("R10 int wr", 1'b1, 1'b1, 1'b0, 16'h0);
    release_bus();
    access(1'b1, 1'b0, 1'b1, 15'h0010);
    check_out("R10 readback", 1'b1, 1'b1, 1'b1, {8'h00, ram_val(8'h08)});
    release_bus();
    @(negedge clk);
    check_out("R11 idle", 1'b1, 1'b1, 1'b0, 16'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_int_reads();
        t_lanes();
        t_external();
        t_no_serial();
        t_int_write();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule